// File: doc/BRIEF.md
# Serial Command/Status Word Transceiver

This block is a link master that trades one 32-bit command word for one 32-bit status word with a remote agent. The link has three wires: a clock that the master drives, a data line that the master drives, and a data line that the master reads. A transfer has three parts. It opens with a start condition, runs 32 clocked bit periods, and closes with a stop condition. The master shifts its command out and shifts the reply in during the same 32 bit periods.

Every level change on a driven wire is followed by a settling interval of `TICK_CYCLES` system clocks before the next change. The user pulses `start_i` with a command word. Some time later the block pulses `done_o` and presents the status word. The top two bits of that status word are the page field of the command that was sent. The lower bits are the values sampled from the remote agent.

Top module: `sxw_xcvr`

## Requirements
- R1: After a synchronous reset, and whenever no transfer is running, `sclk_o` and `sdo_o` are both 1, `busy_o` and `done_o` are 0, and after reset `status_o` is 0.
- R2: A transfer opens with `sdo_o` falling while `sclk_o` is 1. `sclk_o` falls `TICK_CYCLES` cycles later. The first rising edge of `sclk_o` follows the opening fall of `sdo_o` by 3·`TICK_CYCLES` cycles.
- R3: Exactly 32 data bits are sent, command bit 31 first. `sdo_o` is set while `sclk_o` is low and holds steady for the whole high phase. The values present at the 32 rising edges equal the command word.
- R4: Within the data bits, `sclk_o` stays high for `TICK_CYCLES` cycles, and consecutive rising edges are 3·`TICK_CYCLES` cycles apart.
- R5: `sdi_i` is sampled once per bit, at the clock edge that comes `TICK_CYCLES` cycles after that bit's falling edge of `sclk_o`. Each sample enters at the low end of the word, so the first sample ends up as bit 31.
- R6: A transfer closes with a 33rd rising edge of `sclk_o`, `2·TICK_CYCLES` cycles after the 32nd, with `sdo_o` at 0. `sdo_o` then rises `TICK_CYCLES` cycles later while `sclk_o` stays 1.
- R7: Bits 31:30 of `status_o` equal bits 31:30 of the command sent. Bits 29:0 are the sampled values.
- R8: `done_o` is a one-cycle pulse 100·`TICK_CYCLES` cycles after the edge that accepted `start_i`. `status_o` is valid with it and holds until the next completion or reset.
- R9: `busy_o` is 1 from the accepting edge through the `done_o` cycle, and 0 the cycle after. A `start_i` seen while `busy_o` is 1 is ignored: no second frame starts, and the command in flight is unchanged.
- R10: Asserting `rst` in the middle of a transfer returns the wires to idle, drops `busy_o` and clears `status_o`. A following transfer works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse; accepted only when not busy |
| cmd_i | input | 32 | Command word, captured with the accepted request |
| sdi_i | input | 1 | Serial data from the remote agent |
| sclk_o | output | 1 | Link clock, registered |
| sdo_o | output | 1 | Serial data to the remote agent, registered |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 32 | Returned word with the page bits overlaid |

## Verification
Suppose the phase register skips or repeats a state. The edges on `sclk_o` would then be spaced differently, or there would be a number of rising edges other than 33. The model of the remote agent catches that at the next edge, within 3·`TICK_CYCLES` cycles. A sampling point that comes too early or too late shows up in `status_o` when `done_o` pulses. The agent drives the inverted bit outside the legal window, so a bad sampling point always returns a wrong bit. An off-by-one in the bit counter shows up in the completion latency and in the captured command at the end of the frame.

// File: rtl/sxw_pkg.sv
package sxw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START_A,
    PH_START_B,
    PH_BIT_SET,
    PH_BIT_HI,
    PH_BIT_LO,
    PH_STOP_A,
    PH_STOP_B
  } phase_e;
endpackage

// File: rtl/sxw_tick.sv
// Settling-interval timer: counts TICKS cycles per phase while run is high.
module sxw_tick #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LAST)
    else $error("tick counter out of range");
endmodule

// File: rtl/sxw_shift.sv
// Combined transmit/receive shift register plus reported status register.
module sxw_shift #(
  parameter int W      = 32,
  parameter int PAGE_W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] cmd,
  input  logic         shift_en,
  input  logic         sdi,
  input  logic         finish,
  output logic         msb,
  output logic         nxt_msb,
  output logic [W-1:0] status
);
  localparam int LOW_W = W - PAGE_W;

  logic [W-1:0]      word;
  logic [PAGE_W-1:0] page;

  always_ff @(posedge clk) begin
    if (rst) begin
      word   <= '0;
      page   <= '0;
      status <= '0;
    end else begin
      if (load) begin
        word <= cmd;
        page <= cmd[W-1 -: PAGE_W];
      end else if (shift_en) begin
        word <= {word[W-2:0], sdi};
      end
      if (finish) status <= {page, word[LOW_W-1:0]};
    end
  end

  assign msb     = word[W-1];
  assign nxt_msb = word[W-2];

  // R5
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (rst) !(load && shift_en))
    else $error("load and shift in same cycle");
endmodule

// File: rtl/sxw_ctrl.sv
// Phase sequencer: start, 32 bit periods, stop; drives the link pins.
module sxw_ctrl
  import sxw_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic expire,
  input  logic msb,
  input  logic nxt_msb,
  output logic run,
  output logic load,
  output logic shift_en,
  output logic finish,
  output logic sclk,
  output logic sdo,
  output logic busy,
  output logic done
);
  localparam int BCW = $clog2(W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(W - 1);

  phase_e         phase;
  logic [BCW-1:0] bit_idx;

  assign run      = (phase != PH_IDLE);
  assign load     = start && (phase == PH_IDLE) && !busy;
  assign shift_en = expire && (phase == PH_BIT_LO);
  assign finish   = expire && (phase == PH_STOP_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      sclk    <= 1'b1;
      sdo     <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      bit_idx <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (load) begin
            busy  <= 1'b1;
            sdo   <= 1'b0;
            phase <= PH_START_A;
          end else begin
            busy <= 1'b0;
          end
        end
        PH_START_A: if (expire) begin
          sclk  <= 1'b0;
          phase <= PH_START_B;
        end
        PH_START_B: if (expire) begin
          sdo     <= msb;
          bit_idx <= '0;
          phase   <= PH_BIT_SET;
        end
        PH_BIT_SET: if (expire) begin
          sclk  <= 1'b1;
          phase <= PH_BIT_HI;
        end
        PH_BIT_HI: if (expire) begin
          sclk  <= 1'b0;
          phase <= PH_BIT_LO;
        end
        PH_BIT_LO: if (expire) begin
          if (bit_idx == LAST_BIT) begin
            sclk  <= 1'b1;
            sdo   <= 1'b0;
            phase <= PH_STOP_A;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            sdo     <= nxt_msb;
            phase   <= PH_BIT_SET;
          end
        end
        PH_STOP_A: if (expire) begin
          sdo   <= 1'b1;
          phase <= PH_STOP_B;
        end
        PH_STOP_B: if (expire) begin
          done  <= 1'b1;
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> (sclk && sdo)) else $error("idle lines not high");
  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_BIT_HI) && ($past(phase) == PH_BIT_HI)) |-> $stable(sdo))
    else $error("data moved while clock high");
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done)
    else $error("done longer than one cycle");
  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> busy)
    else $error("done without busy");
  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start))
    else $error("busy rose without request");
endmodule

// File: rtl/sxw_xcvr.sv
module sxw_xcvr #(
  parameter int TICK_CYCLES = 4,
  parameter int WORD_W      = 32,
  parameter int PAGE_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] cmd_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] status_o
);
  logic run, expire, load, shift_en, finish, msb, nxt_msb;

  sxw_tick #(.TICKS(TICKS_SAFE)) u_tick (
    .clk(clk), .rst(rst), .run(run), .expire(expire)
  );

  sxw_ctrl #(.W(WORD_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i), .expire(expire),
    .msb(msb), .nxt_msb(nxt_msb), .run(run), .load(load),
    .shift_en(shift_en), .finish(finish), .sclk(sclk_o), .sdo(sdo_o),
    .busy(busy_o), .done(done_o)
  );

  sxw_shift #(.W(WORD_W), .PAGE_W(PAGE_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .cmd(cmd_i), .shift_en(shift_en),
    .sdi(sdi_i), .finish(finish), .msb(msb), .nxt_msb(nxt_msb), .status(status_o)
  );

  localparam int TICKS_SAFE = (TICK_CYCLES < 1) ? 1 : TICK_CYCLES;
endmodule

// File: tb/tb_sxw_xcvr.sv
module tb_sxw_xcvr;
  localparam int N = 4;
  localparam int FRAME = 100 * N;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] cmd_i = '0;
  logic        sdi_i = 1'b1;
  logic        sclk_o, sdo_o, busy_o, done_o;
  logic [31:0] status_o;

  sxw_xcvr #(.TICK_CYCLES(N)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cmd_i(cmd_i), .sdi_i(sdi_i),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .busy_o(busy_o), .done_o(done_o),
    .status_o(status_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int gcyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(input logic [31:0] c, input logic [31:0] r);
    return {c[31:30], r[29:0]};
  endfunction

  // Remote agent model and frame monitor, all sampled at falling clock edges
  logic [31:0] resp_cur = '0;
  logic [31:0] cap = '0;
  int  mcyc = 0, rises = 0, t_start = 0, t_rise = 0, frames = 0, stops = 0, gcnt = 0;
  bit  in_frame = 0, pend = 0, ps = 1, pd = 1;

  always @(negedge clk) begin
    mcyc++;
    if (rst) begin
      in_frame = 0; pend = 0; ps = 1; pd = 1;
    end else begin
      if (!in_frame && ps && sclk_o && pd && !sdo_o) begin
        in_frame = 1; rises = 0; t_start = mcyc; frames++; pend = 0;
        sdi_i = ~resp_cur[31];
      end else if (in_frame) begin
        if (pend) begin
          gcnt++;
          if (gcnt == N) begin sdi_i = ~sdi_i; pend = 0; end
        end
        if (ps && !sclk_o) begin
          if (rises == 0) chk(mcyc - t_start == N, "R2", mcyc - t_start, N);
          else chk(mcyc - t_rise == N, "R4", mcyc - t_rise, N);
          pend = 1; gcnt = 0;
        end
        if (!ps && sclk_o) begin
          if (rises == 0) begin
            chk(mcyc - t_start == 3*N, "R2", mcyc - t_start, 3*N);
          end else if (rises < 32) begin
            chk(mcyc - t_rise == 3*N, "R4", mcyc - t_rise, 3*N);
          end else begin
            chk(mcyc - t_rise == 2*N, "R6", mcyc - t_rise, 2*N);
            chk(sdo_o == 1'b0, "R6", sdo_o, 0);
          end
          if (rises < 32) begin
            cap = {cap[30:0], sdo_o};
            sdi_i = resp_cur[31 - rises];
          end
          t_rise = mcyc;
          rises++;
        end
        if (ps && sclk_o && !pd && sdo_o) begin
          chk(rises == 33, "R6", rises, 33);
          chk(mcyc - t_rise == N, "R6", mcyc - t_rise, N);
          in_frame = 0; stops++;
        end
      end
      ps = sclk_o; pd = sdo_o;
    end
  end

  task automatic run_frame(input logic [31:0] c, input logic [31:0] r, input bit inject);
    int k;
    int f0, s0;
    bit busy_ok;
    resp_cur = r; cap = '0; f0 = frames; s0 = stops; busy_ok = 1;
    @(negedge clk); start_i = 1'b1; cmd_i = c;
    @(negedge clk); start_i = 1'b0; cmd_i = $urandom;
    k = 0;
    while (!done_o && k < FRAME + 50) begin
      if (!busy_o) busy_ok = 0;
      if (inject && k == 50) begin start_i = 1'b1; cmd_i = ~c; end
      if (inject && k == 51) start_i = 1'b0;
      @(negedge clk); k++;
    end
    start_i = 1'b0;
    chk(busy_ok, "R9", busy_ok, 1);
    chk(k == FRAME, "R8", k, FRAME);
    chk(busy_o, "R9", busy_o, 1);
    chk(status_o == exp_status(c, r), "R7", status_o, exp_status(c, r));
    chk(status_o[29:0] == r[29:0], "R5", status_o[29:0], r[29:0]);
    chk(cap == c, "R3", cap, c);
    chk(frames == f0 + 1 && stops == s0 + 1, "R9", frames - f0, 1);
    @(negedge clk);
    chk(!done_o && !busy_o, "R9", {done_o, busy_o}, 0);
    chk(status_o == exp_status(c, r), "R8", status_o, exp_status(c, r));
    chk(sclk_o && sdo_o, "R1", {sclk_o, sdo_o}, 3);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk_o && sdo_o && !busy_o && !done_o && status_o == 0, "R1",
        {sclk_o, sdo_o, busy_o, done_o}, 4'b1100);
    // directed corners
    run_frame(32'h0000_0000, 32'hFFFF_FFFF, 0);
    run_frame(32'hFFFF_FFFF, 32'h0000_0000, 0);
    run_frame(32'hAAAA_5555, 32'h5555_AAAA, 0);
    run_frame(32'h4000_0001, 32'h8000_0003, 1);
    // mid-transfer reset (R10)
    resp_cur = 32'h1234_5678;
    @(negedge clk); start_i = 1'b1; cmd_i = 32'hC0DE_0042;
    @(negedge clk); start_i = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk_o && sdo_o, "R10", {sclk_o, sdo_o}, 3);
    chk(!busy_o && !done_o, "R10", {busy_o, done_o}, 0);
    chk(status_o == 0, "R10", status_o, 0);
    run_frame(32'h8765_4321, 32'h0F0F_F0F0, 0);
    // random traffic
    for (int i = 0; i < 24; i++) begin
      logic [31:0] c, r;
      c = $urandom; r = $urandom;
      run_frame(c, r, (i % 5) == 2);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    gcyc++;
    if (gcyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000", gcyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule